// File: doc/BRIEF.md
# Pixel Output Port Multiplexer

The block accepts one 24-bit pixel word per pixel period from a valid/ready stream. It spreads that word over two 8-bit output ports and a 24-bit parallel bus. The block runs on a single system clock, and a phase counter stands in for the edges of a slower pixel clock.

An 8-bit configuration input picks the output format:

- **Parallel:** one system clock per pixel.
- **Double:** two phases per pixel.
- **Triple:** three phases per pixel.

In double and triple formats, port A time-shares the bytes of the pixel. Port B always carries the low byte.

The same configuration input also controls these functions:

- **Blanking:** data is forced to zero outside active video.
- **Active-video delay:** the active-video flag is delayed against the data by zero to three clocks.
- **Pixel clock:** an output-enable and a generated pixel clock are driven for a pad.
- **Line length:** active pixels in each line are counted and the count is latched at the end of the line.

Back-pressure rules are as follows:

- `pix_ready` rises on the last phase of the current pixel period. A transfer happens on a clock edge where `pix_valid` and `pix_ready` are both high.
- While `pix_valid` is high and `pix_ready` is low, the source must hold `pix_data` and `pix_act`.
- If no transfer happens when ready is offered, the outputs keep presenting the previous word for another period.

Top module: `pxmux_top`

## Requirements
- R1: The mode is `cfg[1:0]`. The pixel period is 2 clocks in mode 01, 3 clocks in mode 11, and 1 clock in modes 00 and 10. The phase counts from 0 to the period minus 1 and wraps. `pix_ready` is high on the last phase. An accepted word is presented from the next clock on and is held until the next transfer.
- R2: In mode 00, `par_word` equals the held word, `port_a` equals its bits [23:16] and `port_b` equals its bits [7:0].
- R3: In mode 01, `port_a` shows bits [23:16] on phase 0 and bits [15:8] on phase 1. `port_b` shows bits [7:0] and `par_word` is zero.
- R4: In mode 11, `port_a` shows bits [23:16], [15:8] and [7:0] on phases 0, 1 and 2. `port_b` shows bits [7:0] and `par_word` is zero.
- R5: Mode 10 is reserved. `port_a`, `port_b` and `par_word` are all zero.
- R6: When `cfg[2]` is 1, a word accepted with `pix_act` low is stored as zero on every byte lane.
- R7: The `pix_act` value of each transfer is held and presented on `act_out`. It is delayed by `cfg[5:4]` extra clocks, where code n gives n clocks. With code 00, `act_out` changes in the same clock as the data.
- R8: `pclk_oe` equals `cfg[3]`. `pclk_out` is high on phase 0 when `cfg[3]` is 1, and is low otherwise.
- R9: When `cfg[7]` is 1, the block counts the active pixels of each line:
  - A transfer with `pix_act` high after one with it low restarts the count at 1.
  - Each further transfer with `pix_act` high adds 1.
  - A transfer with `pix_act` low after one with it high copies the count to `line_len` on the following clock.
- R10: The line count saturates at 4095.
- R11: When `cfg[7]` is 0, the count does not advance and `line_len` keeps its value.
- R12: During reset, the held word, phase, active flag, delay stages, count and `line_len` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg | input | 8 | Configuration: mode, blanking, clock source, delay, count enable |
| pix_valid | input | 1 | Source offers a pixel |
| pix_ready | output | 1 | Block takes a pixel on this clock |
| pix_data | input | 24 | Pixel word |
| pix_act | input | 1 | Active-video flag of the pixel |
| port_a | output | 8 | Time-shared byte port |
| port_b | output | 8 | Low-byte port |
| par_word | output | 24 | Full word in parallel mode |
| act_out | output | 1 | Delayed active-video flag |
| pclk_oe | output | 1 | Pixel clock output enable |
| pclk_out | output | 1 | Generated pixel clock |
| line_len | output | 12 | Latched active pixel count of the last line |

## Verification
A wrong phase shows up at once, in the same clock, in two places: `pix_ready` and the byte on `port_a`. A corrupted held word shows on `port_b` or `par_word` in the clock after the transfer.

Faults in the delay stages reach `act_out` only after the programmed one to three clocks. A bad line count stays hidden until the end of the line, when it is latched into `line_len`. For that reason the lines in the test are kept short, with one long line used to reach saturation.

// File: rtl/pxmux_pkg.sv
package pxmux_pkg;
  typedef enum logic [1:0] {
    MODE_PAR = 2'b00,
    MODE_DBL = 2'b01,
    MODE_RSV = 2'b10,
    MODE_TRI = 2'b11
  } mode_e;

  localparam int CFG_BLANK = 2;
  localparam int CFG_CLKSRC = 3;
  localparam int CFG_DLY_LO = 4;
  localparam int CFG_CNT_EN = 7;

  function automatic logic [1:0] last_phase(input mode_e m);
    case (m)
      MODE_DBL: return 2'd1;
      MODE_TRI: return 2'd2;
      default:  return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/pxmux_phase.sv
module pxmux_phase
  import pxmux_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  mode_e      mode,
  output logic [1:0] phase,
  output logic       at_last
);
  logic [1:0] last;

  always_comb begin
    last    = last_phase(mode);
    at_last = (phase >= last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       phase <= '0;
    else if (at_last) phase <= '0;
    else              phase <= phase + 2'd1;
  end
endmodule

// File: rtl/pxmux_lanes.sv
module pxmux_lanes
  import pxmux_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 3
) (
  input  mode_e                      mode,
  input  logic [1:0]                 phase,
  input  logic [LANE_W*LANES-1:0]    word,
  output logic [LANE_W-1:0]          port_a,
  output logic [LANE_W-1:0]          port_b,
  output logic [LANE_W*LANES-1:0]    par_word
);
  localparam int WORD_W = LANE_W * LANES;

  logic [LANE_W-1:0] lane [LANES];

  // lane 0 is the most significant byte
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word[WORD_W-1-g*LANE_W -: LANE_W];
  end

  always_comb begin
    port_a   = '0;
    port_b   = '0;
    par_word = '0;
    case (mode)
      MODE_PAR: begin
        port_a   = lane[0];
        port_b   = lane[LANES-1];
        par_word = word;
      end
      MODE_DBL: begin
        port_a = (phase == 2'd0) ? lane[0] : lane[1];
        port_b = lane[LANES-1];
      end
      MODE_TRI: begin
        for (int k = 0; k < LANES; k++)
          if (int'(phase) == k) port_a = lane[k];
        port_b = lane[LANES-1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pxmux_vdelay.sv
module pxmux_vdelay #(
  parameter int MAX_DLY = 3,
  localparam int SEL_W = $clog2(MAX_DLY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_in,
  input  logic [SEL_W-1:0] sel,
  output logic             act_out
);
  logic [MAX_DLY:0] tap;

  assign tap[0] = act_in;

  for (genvar i = 1; i <= MAX_DLY; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) tap[i] <= 1'b0;
      else        tap[i] <= tap[i-1];
    end
  end

  always_comb begin
    act_out = 1'b0;
    for (int k = 0; k <= MAX_DLY; k++)
      if (int'(sel) == k) act_out = tap[k];
  end
endmodule

// File: rtl/pxmux_linecnt.sv
module pxmux_linecnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             take,
  input  logic             act_new,
  input  logic             act_prev,
  output logic [CNT_W-1:0] line_len
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      line_len <= '0;
    end else if (en && take) begin
      if (act_new && !act_prev)        count <= {{(CNT_W-1){1'b0}}, 1'b1};
      else if (act_new && count != CNT_MAX) count <= count + 1'b1;
      if (!act_new && act_prev)        line_len <= count;
    end
  end
endmodule

// File: rtl/pxmux_top.sv
module pxmux_top
  import pxmux_pkg::*;
#(
  parameter int LANE_W  = 8,
  parameter int LANES   = 3,
  parameter int CNT_W   = 12,
  parameter int MAX_DLY = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [7:0]               cfg,
  input  logic                     pix_valid,
  output logic                     pix_ready,
  input  logic [LANE_W*LANES-1:0]  pix_data,
  input  logic                     pix_act,
  output logic [LANE_W-1:0]        port_a,
  output logic [LANE_W-1:0]        port_b,
  output logic [LANE_W*LANES-1:0]  par_word,
  output logic                     act_out,
  output logic                     pclk_oe,
  output logic                     pclk_out,
  output logic [CNT_W-1:0]         line_len
);
  localparam int WORD_W = LANE_W * LANES;
  localparam int SEL_W  = $clog2(MAX_DLY + 1);

  mode_e             mode;
  logic [1:0]        phase;
  logic              take;
  logic [WORD_W-1:0] held;
  logic              act_q;

  assign mode = mode_e'(cfg[1:0]);
  assign take = pix_valid && pix_ready;

  pxmux_phase u_phase (
    .clk(clk), .rst_n(rst_n), .mode(mode), .phase(phase), .at_last(pix_ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held  <= '0;
      act_q <= 1'b0;
    end else if (take) begin
      held  <= (cfg[CFG_BLANK] && !pix_act) ? '0 : pix_data;
      act_q <= pix_act;
    end
  end

  pxmux_lanes #(.LANE_W(LANE_W), .LANES(LANES)) u_lanes (
    .mode(mode), .phase(phase), .word(held),
    .port_a(port_a), .port_b(port_b), .par_word(par_word)
  );

  pxmux_vdelay #(.MAX_DLY(MAX_DLY)) u_vdelay (
    .clk(clk), .rst_n(rst_n), .act_in(act_q),
    .sel(cfg[CFG_DLY_LO +: SEL_W]), .act_out(act_out)
  );

  pxmux_linecnt #(.CNT_W(CNT_W)) u_linecnt (
    .clk(clk), .rst_n(rst_n), .en(cfg[CFG_CNT_EN]), .take(take),
    .act_new(pix_act), .act_prev(act_q), .line_len(line_len)
  );

  assign pclk_oe  = cfg[CFG_CLKSRC];
  assign pclk_out = cfg[CFG_CLKSRC] && (phase == 2'd0);
endmodule

// File: rtl/pxmux_chk.sv
module pxmux_chk #(
  parameter int LANE_W = 8,
  parameter int LANES  = 3,
  parameter int CNT_W  = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [7:0]              cfg,
  input logic                    pix_valid,
  input logic                    pix_ready,
  input logic                    pix_act,
  input logic [LANE_W-1:0]       port_a,
  input logic [LANE_W-1:0]       port_b,
  input logic [LANE_W*LANES-1:0] par_word,
  input logic                    act_out,
  input logic                    pclk_oe,
  input logic                    pclk_out
);
  localparam int WORD_W = LANE_W * LANES;

  a_r1_parallel_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[1:0] == 2'b00) |-> pix_ready);

  a_r3_ready_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[1:0] == 2'b01 && pix_ready && $stable(cfg)) |=>
      (cfg[1:0] != 2'b01 || !pix_ready));

  a_r2_ports_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[1:0] == 2'b00) |->
      (port_a == par_word[WORD_W-1 -: LANE_W] && port_b == par_word[LANE_W-1:0]));

  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[1:0] == 2'b10) |-> (port_a == '0 && port_b == '0 && par_word == '0));

  a_r6_blanked: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready && cfg[2] && !pix_act && cfg[1:0] == 2'b00) |=>
      (cfg[1:0] != 2'b00 || par_word == '0));

  a_r7_no_delay_follows_take: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_out) && cfg[5:4] == 2'b00 && $past(cfg[5:4]) == 2'b00) |->
      $past(pix_valid && pix_ready));

  a_r8_clock_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    pclk_out |-> pclk_oe);
endmodule

bind pxmux_top pxmux_chk #(.LANE_W(LANE_W), .LANES(LANES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg(cfg), .pix_valid(pix_valid),
  .pix_ready(pix_ready), .pix_act(pix_act), .port_a(port_a), .port_b(port_b),
  .par_word(par_word), .act_out(act_out), .pclk_oe(pclk_oe), .pclk_out(pclk_out)
);

// File: tb/test_pxmux_top.sv
module test_pxmux_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg = 8'h00;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [23:0] pix_data = '0;
  logic        pix_act = 1'b0;
  logic [7:0]  port_a, port_b;
  logic [23:0] par_word;
  logic        act_out, pclk_oe, pclk_out;
  logic [11:0] line_len;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1357_9bdf;

  // reference model state
  int m_phase = 0;
  int m_word = 0;
  int m_act = 0;
  int m_hist[4] = '{0, 0, 0, 0};
  int m_cnt = 0;
  int m_len = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pxmux_top i_pxmux_top (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_data(pix_data), .pix_act(pix_act),
    .port_a(port_a), .port_b(port_b), .par_word(par_word), .act_out(act_out),
    .pclk_oe(pclk_oe), .pclk_out(pclk_out), .line_len(line_len)
  );

  function automatic int period_last(input logic [1:0] m);
    if (m == 2'b01) return 1;
    if (m == 2'b11) return 2;
    return 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // model update on every clock edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_phase = 0; m_word = 0; m_act = 0; m_cnt = 0; m_len = 0;
      m_hist = '{0, 0, 0, 0};
    end else begin
      int last;
      bit take;
      last = period_last(cfg[1:0]);
      take = pix_valid && (m_phase >= last);
      m_hist[3] = m_hist[2]; m_hist[2] = m_hist[1]; m_hist[1] = m_act;
      if (take) begin
        if (cfg[7]) begin
          if (pix_act && m_act == 0) m_cnt = 1;
          else if (pix_act && m_cnt < 4095) m_cnt = m_cnt + 1;
          if (!pix_act && m_act == 1) m_len = m_cnt;
        end
        m_word = (cfg[2] && !pix_act) ? 0 : int'(pix_data);
        m_act = pix_act ? 1 : 0;
      end
      m_phase = (m_phase >= last) ? 0 : m_phase + 1;
    end
    m_hist[0] = m_act;
  end

  // compare on the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int last, ea, eb, ep;
      string dtag;
      last = period_last(cfg[1:0]);
      ea = 0; eb = 0; ep = 0;
      case (cfg[1:0])
        2'b00: begin ea = (m_word >> 16) & 255; eb = m_word & 255; ep = m_word; dtag = "R2"; end
        2'b01: begin ea = (m_phase == 0) ? ((m_word >> 16) & 255) : ((m_word >> 8) & 255);
                     eb = m_word & 255; dtag = "R3"; end
        2'b11: begin ea = (m_word >> (16 - 8*m_phase)) & 255; eb = m_word & 255; dtag = "R4"; end
        default: dtag = "R5";
      endcase
      if (cfg[2]) dtag = {dtag, "/R6"};
      chk("R1 ready", int'(pix_ready), (m_phase >= last) ? 1 : 0);
      chk({dtag, " port_a"}, int'(port_a), ea);
      chk({dtag, " port_b"}, int'(port_b), eb);
      chk({dtag, " par_word"}, int'(par_word), ep);
      chk("R7 act_out", int'(act_out), m_hist[cfg[5:4]]);
      chk("R8 pclk_oe", int'(pclk_oe), int'(cfg[3]));
      chk("R8 pclk_out", int'(pclk_out), (cfg[3] && m_phase == 0) ? 1 : 0);
      if (!cfg[7])          chk("R11 line_len", int'(line_len), m_len);
      else if (m_len == 4095) chk("R10 line_len", int'(line_len), m_len);
      else                  chk("R9 line_len", int'(line_len), m_len);
    end
  end

  always @(posedge clk) begin
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic run(input logic [7:0] c, input int n, input int on, input int per, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      cfg = c;
      pix_valid = (gap == 0) || (i % gap != 0);
      seed = seed * 32'd1103515245 + 32'd12345;
      pix_data = seed[31:8];
      pix_act = ((i % per) < on);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state observed at the ports
    chk("R12 port_a", int'(port_a), 0);
    chk("R12 port_b", int'(port_b), 0);
    chk("R12 par_word", int'(par_word), 0);
    chk("R12 act_out", int'(act_out), 0);
    chk("R12 line_len", int'(line_len), 0);
    chk("R12 ready", int'(pix_ready), 1);
    #1 rst_n = 1'b1;
    run(8'h80, 40, 5, 8, 0);    // R2 R9 parallel lines
    run(8'h80, 40, 4, 9, 3);    // R1 gaps in valid
    run(8'h81, 60, 7, 12, 0);   // R3 double
    run(8'h81, 40, 5, 10, 4);   // R3 with gaps
    run(8'h83, 60, 9, 15, 0);   // R4 triple
    run(8'h83, 45, 6, 11, 5);
    run(8'h84, 40, 3, 7, 0);    // R6 blanking in each mode
    run(8'h85, 40, 6, 10, 0);
    run(8'h87, 45, 9, 14, 0);
    run(8'h90, 30, 2, 5, 0);    // R7 delays
    run(8'hA0, 30, 3, 7, 0);
    run(8'hB0, 30, 1, 4, 0);
    run(8'hB1, 40, 5, 9, 0);
    run(8'h82, 20, 2, 5, 0);    // R5 reserved
    run(8'h88, 20, 3, 6, 0);    // R8 clock source
    run(8'h89, 20, 4, 8, 0);
    run(8'h8B, 30, 6, 12, 0);
    run(8'h00, 40, 3, 7, 0);    // R11 counting disabled
    run(8'h80, 4110, 4110, 5000, 0); // R10 saturation
    run(8'h80, 10, 0, 5, 0);
    run(8'h80, 10, 4, 8, 0);
    done = 1;
    finish_run();
  end
endmodule